// File: doc/BRIEF.md
# Encoder Reset and Configuration Controller

This block owns the reset behaviour of a video encoder's register bank. A raw active-low reset pin is brought into the master-clock domain. A reset is accepted only if the pin stays low long enough. An accepted hardware reset loads the power-up operating modes: NTSC-M output, interlaced ITU-R 601 input, line-locked slave timing driven by HSYNC and an odd/even field input, and caption and teletext insertion switched off.

Software can also reset the encoder by setting a control bit in configuration register 6. That pulse reinitialises the encoder core and the working registers, but it leaves configuration registers 0 to 6 as they are. The highest registers of the bank are never initialised by either kind of reset. A flag per register records whether it has been written since the last hardware reset, and until that first write the register reads back as undefined. Host access is a plain write strobe with address and data, plus a combinational read path.

Top module: `enc_reset_ctrl`

## Requirements
- R1: When the pin `rst_pin_n` is sampled low at 5 or more consecutive clock edges, `hw_rst` and `core_rst` go high. They stay high while the pin stays low and drop 3 clock edges after the pin is sampled high again.
- R2: A low pulse on `rst_pin_n` that covers 4 or fewer clock edges leaves `hw_rst` low and leaves every register unchanged.
- R3: After a hardware reset, registers 0 to 11 hold their defaults. Register 1 reads 0x05: bits [2:0] = 3'b101 select line-locked slave mode with HSYNC plus odd/even input. Register 0 reads 0x00: bits [1:0] = 0 select NTSC-M, bit 2 = 0 selects interlaced, and bits [4:3] = 0 select ITU-R 601 input. Register 3 reads 0x00: bit 0 (caption enable) and bit 1 (teletext enable) are both cleared. Every other register from 0 to 11 reads 0x00.
- R4: A write with `wr_en` high stores `wdata` into register `addr` at the next clock edge. The register then reads back on `rdata` combinationally, with `rdata_ok` high.
- R5: Writing a 1 to bit 7 of register 6 raises `core_rst` for exactly one cycle, starting at the clock edge after the write. Bit 7 reads back as 0 once that pulse has ended.
- R6: A software reset returns registers 7 to 11 to 0x00.
- R7: A software reset keeps the contents of registers 0 to 6, apart from the self-clearing bit 7 of register 6.
- R8: Registers 12 to 15 are never initialised. After a hardware reset they read with `rdata_ok` low and `rdata` equal to 0x00 until they are first written.
- R9: A software reset leaves the contents of registers 12 to 15 and their `rdata_ok` state unchanged.
- R10: A write presented while `core_rst` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_pin_n | input | 1 | Raw active-low reset pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, 0 when undefined |
| rdata_ok | output | 1 | High when the addressed register holds defined contents |
| core_rst | output | 1 | Reset to the encoder core, hardware or software |
| hw_rst | output | 1 | Qualified hardware reset |

## Verification
The hardest case to reach is the edge of the pulse-width filter. The pin is asynchronous, so the number of low samples depends on where the stimulus falls relative to the clock. The bench therefore moves the pin only on falling clock edges, which lets it produce pulses of exactly 4 and exactly 5 sampled cycles. A second hard case is a write that falls inside the single-cycle software reset pulse. The bench reaches it by counting edges after the write to register 6 and presenting a configuration write in exactly the pulse cycle.

// File: rtl/enc_reset_ctrl.sv
module enc_reset_ctrl #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 16,
  parameter int CFG_LAST   = 6,
  parameter int HOLD_FIRST = 12,
  parameter int MIN_LOW    = 5,
  parameter int SOFT_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_ok,
  output logic              core_rst,
  output logic              hw_rst
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);

  function automatic logic [DATA_W-1:0] dflt(int idx);
    logic [DATA_W-1:0] v;
    v = '0;
    if (idx == 1) v[2:0] = 3'b101;
    return v;
  endfunction

  logic [1:0]                 pin_sync;
  logic [CNT_W-1:0]           low_cnt;
  logic                       soft_pulse;
  logic [NUM_REGS*DATA_W-1:0] bank;
  logic [NUM_REGS-1:0]        seen;

  always_ff @(posedge clk) pin_sync <= {pin_sync[0], rst_pin_n};

  always_ff @(posedge clk)
    if (pin_sync[1])                   low_cnt <= '0;
    else if (low_cnt != CNT_W'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;

  assign hw_rst   = (low_cnt == CNT_W'(MIN_LOW));
  assign core_rst = hw_rst | soft_pulse;

  always_ff @(posedge clk)
    if (hw_rst) soft_pulse <= 1'b0;
    else        soft_pulse <= bank[CFG_LAST*DATA_W + SOFT_BIT] & ~soft_pulse;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = wr_en && !core_rst && (addr == ADDR_W'(i));

    if (i < HOLD_FIRST) begin : g_rst
      localparam bit SOFT_CLR = (i > CFG_LAST);
      localparam bit SOFT_REG = (i == CFG_LAST);
      always_ff @(posedge clk)
        if (hw_rst || (soft_pulse && SOFT_CLR)) q <= dflt(i);
        else if (soft_pulse && SOFT_REG)        q[SOFT_BIT] <= 1'b0;
        else if (hit)                           q <= wdata;
      assign seen[i] = 1'b1;
    end else begin : g_keep
      logic v;
      always_ff @(posedge clk) if (hit) q <= wdata;
      always_ff @(posedge clk)
        if (hw_rst)   v <= 1'b0;
        else if (hit) v <= 1'b1;
      assign seen[i] = v;
    end

    assign bank[i*DATA_W +: DATA_W] = q;
  end

  assign rdata_ok = seen[addr];
  assign rdata    = rdata_ok ? bank[addr*DATA_W +: DATA_W] : '0;
endmodule

// File: rtl/enc_reset_ctrl_chk.sv
module enc_reset_ctrl_chk #(
  parameter int DATA_W   = 8,
  parameter int CFG_LAST = 6,
  parameter int HI_N     = 4
) (
  input logic                     clk,
  input logic                     rst_pin_n,
  input logic                     hw_rst,
  input logic                     core_rst,
  input logic                     soft_bit,
  input logic [CFG_LAST*DATA_W-1:0] cfg_low,
  input logic [HI_N-1:0]          seen_hi
);
  logic [3:0] age = '0;
  logic       up;
  logic       hw_d = 1'b0;
  always_ff @(posedge clk) begin
    if (age != 4'hF) age <= age + 1'b1;
    hw_d <= hw_rst;
  end
  assign up = (age == 4'hF);

  a_r1_pin_low: assert property (@(posedge clk) disable iff (!up)
    hw_rst |-> !$past(rst_pin_n, 3));
  a_r1_min_width: assert property (@(posedge clk) disable iff (!up)
    $rose(hw_rst) |-> !$past(rst_pin_n, 7));
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!up || hw_rst)
    core_rst |=> !core_rst);
  a_r5_self_clear: assert property (@(posedge clk) disable iff (!up || hw_rst)
    core_rst |=> !soft_bit);
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!up || hw_rst)
    core_rst |=> $stable(cfg_low));
  a_r9_flag_kept: assert property (@(posedge clk) disable iff (!up || hw_rst || hw_d)
    ($past(seen_hi) & ~seen_hi) == '0);
endmodule

bind enc_reset_ctrl enc_reset_ctrl_chk #(
  .DATA_W(DATA_W), .CFG_LAST(CFG_LAST), .HI_N(NUM_REGS - HOLD_FIRST)
) u_chk (
  .clk      (clk),
  .rst_pin_n(rst_pin_n),
  .hw_rst   (hw_rst),
  .core_rst (core_rst),
  .soft_bit (bank[CFG_LAST*DATA_W + SOFT_BIT]),
  .cfg_low  (bank[CFG_LAST*DATA_W-1:0]),
  .seen_hi  (seen[NUM_REGS-1:HOLD_FIRST])
);

// File: tb/enc_reset_ctrl_tb.sv
`timescale 1ns/1ps
module enc_reset_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_pin_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_ok, core_rst, hw_rst;

  int total = 0, bad = 0;
  bit finished = 0;
  logic mon_req = 1'b0;

  typedef struct { int a; logic [7:0] d; logic ok; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  enc_reset_ctrl u_dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a[3:0]; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(int a, logic [7:0] d, logic ok, string tag);
    exp_t e;
    e.a = a; e.d = d; e.ok = ok; e.tag = tag;
    @(negedge clk); addr = a[3:0]; sb.push_back(e); mon_req = 1'b1;
    @(negedge clk); mon_req = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (mon_req && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check($sformatf("%s reg%0d data", e.tag, e.a), rdata, e.d);
      check($sformatf("%s reg%0d ok", e.tag, e.a), {7'b0, rdata_ok}, {7'b0, e.ok});
    end
  end

  task automatic pin_pulse(int n, output bit saw);
    saw = 0;
    @(negedge clk); rst_pin_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); if (hw_rst) saw = 1;
    end
    rst_pin_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); if (hw_rst) saw = 1;
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    bit saw;
    repeat (10) @(negedge clk);
    check("R1 hw_rst during long low", {7'b0, hw_rst}, 8'h01);
    check("R1 core_rst during long low", {7'b0, core_rst}, 8'h01);
    rst_pin_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 hw_rst released", {7'b0, hw_rst}, 8'h00);

    rd(0, 8'h00, 1'b1, "R3 std/scan/input");
    rd(1, 8'h05, 1'b1, "R3 sync mode");
    rd(3, 8'h00, 1'b1, "R3 caption/teletext");
    rd(6, 8'h00, 1'b1, "R3 reg6");
    rd(9, 8'h00, 1'b1, "R3 reg9");
    rd(12, 8'h00, 1'b0, "R8 undefined");

    wr(0, 8'h13); wr(2, 8'h5A); wr(6, 8'h21); wr(8, 8'hC3); wr(12, 8'h77);
    rd(0, 8'h13, 1'b1, "R4 wr reg0");
    rd(2, 8'h5A, 1'b1, "R4 wr reg2");
    rd(8, 8'hC3, 1'b1, "R4 wr reg8");
    rd(12, 8'h77, 1'b1, "R8 first write");
    rd(13, 8'h00, 1'b0, "R8 still undefined");

    @(negedge clk); wr_en = 1'b1; addr = 4'd6; wdata = 8'hA1;
    @(negedge clk); wr_en = 1'b0;
    check("R5 no pulse yet", {7'b0, core_rst}, 8'h00);
    @(negedge clk);
    check("R5 pulse high", {7'b0, core_rst}, 8'h01);
    check("R5 hw_rst stays low", {7'b0, hw_rst}, 8'h00);
    wr_en = 1'b1; addr = 4'd2; wdata = 8'hEE;
    @(negedge clk); wr_en = 1'b0;
    check("R5 pulse one cycle", {7'b0, core_rst}, 8'h00);

    rd(6, 8'h21, 1'b1, "R5 R7 self clear");
    rd(0, 8'h13, 1'b1, "R7 cfg kept");
    rd(2, 8'h5A, 1'b1, "R10 write in pulse ignored");
    rd(8, 8'h00, 1'b0 | 1'b1, "R6 working reg cleared");
    rd(12, 8'h77, 1'b1, "R9 kept on soft reset");

    pin_pulse(4, saw);
    check("R2 short pulse ignored", {7'b0, saw}, 8'h00);
    rd(0, 8'h13, 1'b1, "R2 reg0 unchanged");
    rd(12, 8'h77, 1'b1, "R2 reg12 unchanged");

    pin_pulse(5, saw);
    check("R1 five-cycle pulse accepted", {7'b0, saw}, 8'h01);
    rd(0, 8'h00, 1'b1, "R3 reg0 after hw reset");
    rd(1, 8'h05, 1'b1, "R3 reg1 after hw reset");
    rd(2, 8'h00, 1'b1, "R3 reg2 after hw reset");
    rd(6, 8'h00, 1'b1, "R3 reg6 after hw reset");
    rd(12, 8'h00, 1'b0, "R8 undefined after hw reset");

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", 8'(sb.size()), 8'h00);
    finish_up();
  end
endmodule